// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces one active-low interrupt flag for each of the two ports of a shared dual-port memory. The two highest addresses of the memory are reserved as mailbox words, one per port. When one port writes the mailbox word that belongs to the other port, the other port's flag goes low. The receiving port then clears its flag by reading its own mailbox word.

The mailbox words themselves stay in the ordinary memory array and keep their normal read/write behaviour. This block only watches each port's address and control strobes. It also takes the per-port busy indications from the collision arbiter: while a port is flagged busy, that port can neither set nor clear a flag. Everything is sampled on one clock, and the flags come from registers, so a flag changes on the clock edge after the access that causes it.

Top module: `mbx_irq_flags`

## Requirements
- R1: While `rst` is high, both `a_irq_n` and `b_irq_n` are high (inactive) after the next clock edge.
- R2: A cycle with `b_en_n`=0, `b_wr_n`=0 and `b_addr` = 2^ADDR_W-2 (port A's mailbox; 1FFE hex for ADDR_W=13, FFE for ADDR_W=12) drives `a_irq_n` low after the next edge.
- R3: A cycle with `a_en_n`=0, `a_wr_n`=0 and `a_addr` = 2^ADDR_W-1 (port B's mailbox; 1FFF hex for ADDR_W=13, FFF for ADDR_W=12) drives `b_irq_n` low after the next edge.
- R4: A cycle with `a_en_n`=0, `a_oe_n`=0 and `a_addr` = 2^ADDR_W-2 drives `a_irq_n` high after the next edge, whatever the value of `a_wr_n`.
- R5: A cycle with `b_en_n`=0, `b_oe_n`=0 and `b_addr` = 2^ADDR_W-1 drives `b_irq_n` high after the next edge, whatever the value of `b_wr_n`.
- R6: While the acting port's busy input (`a_busy_n` or `b_busy_n`) is 0, that port's set or clear access leaves the affected flag unchanged.
- R7: If a set and a clear of the same flag occur in the same cycle, the flag ends up low (set wins).
- R8: Accesses that match neither rule leave both flags unchanged. This includes accesses to other addresses, a write by the owner to its own mailbox with `oe_n` high, a read by the opposite port, and any access with `en_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_addr | input | ADDR_W | Port A address |
| a_en_n | input | 1 | Port A select, active low |
| a_wr_n | input | 1 | Port A write strobe, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_busy_n | input | 1 | Port A busy from arbiter, active low |
| b_addr | input | ADDR_W | Port B address |
| b_en_n | input | 1 | Port B select, active low |
| b_wr_n | input | 1 | Port B write strobe, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_busy_n | input | 1 | Port B busy from arbiter, active low |
| a_irq_n | output | 1 | Port A interrupt flag, active low |
| b_irq_n | output | 1 | Port B interrupt flag, active low |

## Verification
The bench aims at the cases where the two mailbox addresses could be swapped or confused. For example, a port writing its own mailbox must not raise its own flag, and a read by the wrong port must not clear anything. A design that swapped the addresses would raise the wrong flag or ignore the correct one. The bench clears with `wr_n` both low and high, which catches a clear that wrongly depends on the write strobe. It also holds busy low during set and clear attempts, which catches a design that drops the gate. Finally, it issues a set and a clear of the same flag in one cycle, where a design with clear priority would leave the flag high.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  localparam int NPORTS = 2;

  // Mailbox word owned by port idx: A (0) gets top-1, B (1) gets top.
  function automatic int unsigned mbx_addr(input int unsigned aw, input int unsigned idx);
    return (32'd1 << aw) - 32'd2 + idx;
  endfunction

  typedef struct packed {
    logic set;
    logic clr;
  } flag_req_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
  parameter int ADDR_W   = 13,
  parameter int OWN_MBX  = 8190,
  parameter int PEER_MBX = 8191
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic              busy_n,
  output logic              peer_set,
  output logic              own_clr
);
  localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(OWN_MBX);
  localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(PEER_MBX);

  logic active;

  always_comb begin
    active   = !en_n && busy_n;
    peer_set = active && !wr_n && (addr == PEER_A);
    own_clr  = active && !oe_n && (addr == OWN_A);
  end
endmodule

// File: rtl/mbx_flag_cell.sv
module mbx_flag_cell
  import mbx_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flag_req_t req,
  output logic      flag_n
);
  always_ff @(posedge clk) begin
    if (rst)          flag_n <= 1'b1;
    else if (req.set) flag_n <= 1'b0;
    else if (req.clr) flag_n <= 1'b1;
  end

  // R2 R3 R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    req.set |=> !flag_n);

  // R4 R5
  clr_chk: assert property (@(posedge clk) disable iff (rst)
    (req.clr && !req.set) |=> flag_n);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!req.set && !req.clr) |=> $stable(flag_n));
endmodule

// File: rtl/mbx_irq_flags.sv
module mbx_irq_flags
  import mbx_irq_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_en_n,
  input  logic              a_wr_n,
  input  logic              a_oe_n,
  input  logic              a_busy_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_en_n,
  input  logic              b_wr_n,
  input  logic              b_oe_n,
  input  logic              b_busy_n,
  output logic              a_irq_n,
  output logic              b_irq_n
);
  logic [ADDR_W-1:0] addr_v [NPORTS];
  logic [NPORTS-1:0] en_v, wr_v, oe_v, busy_v;
  logic [NPORTS-1:0] peer_set_v, own_clr_v, flag_v;
  flag_req_t         req_v [NPORTS];

  assign addr_v[0] = a_addr;
  assign addr_v[1] = b_addr;
  assign en_v   = {b_en_n, a_en_n};
  assign wr_v   = {b_wr_n, a_wr_n};
  assign oe_v   = {b_oe_n, a_oe_n};
  assign busy_v = {b_busy_n, a_busy_n};

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    mbx_port_decode #(
      .ADDR_W  (ADDR_W),
      .OWN_MBX (int'(mbx_addr(ADDR_W, p))),
      .PEER_MBX(int'(mbx_addr(ADDR_W, NPORTS - 1 - p)))
    ) u_dec (
      .addr    (addr_v[p]),
      .en_n    (en_v[p]),
      .wr_n    (wr_v[p]),
      .oe_n    (oe_v[p]),
      .busy_n  (busy_v[p]),
      .peer_set(peer_set_v[p]),
      .own_clr (own_clr_v[p])
    );

    assign req_v[p].set = peer_set_v[NPORTS - 1 - p];
    assign req_v[p].clr = own_clr_v[p];

    mbx_flag_cell u_flag (
      .clk   (clk),
      .rst   (rst),
      .req   (req_v[p]),
      .flag_n(flag_v[p])
    );
  end

  assign a_irq_n = flag_v[0];
  assign b_irq_n = flag_v[1];

  // R1
  rst_idle_chk: assert property (@(posedge clk)
    rst |=> (a_irq_n && b_irq_n));

  // R6
  a_busy_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!b_busy_n && !own_clr_v[0]) |=> $stable(a_irq_n));

  // R6
  b_busy_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!a_busy_n && !own_clr_v[1]) |=> $stable(b_irq_n));
endmodule

// File: tb/mbx_irq_flags_tb.sv
module mbx_irq_flags_tb;
  localparam int AW = 13;
  localparam logic [AW-1:0] MBA = 13'h1FFE;
  localparam logic [AW-1:0] MBB = 13'h1FFF;

  logic clk = 1'b0;
  logic rst;
  logic [AW-1:0] a_addr, b_addr;
  logic a_en_n, a_wr_n, a_oe_n, a_busy_n;
  logic b_en_n, b_wr_n, b_oe_n, b_busy_n;
  logic a_irq_n, b_irq_n;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  mbx_irq_flags #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst),
    .a_addr(a_addr), .a_en_n(a_en_n), .a_wr_n(a_wr_n), .a_oe_n(a_oe_n), .a_busy_n(a_busy_n),
    .b_addr(b_addr), .b_en_n(b_en_n), .b_wr_n(b_wr_n), .b_oe_n(b_oe_n), .b_busy_n(b_busy_n),
    .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    a_addr = '0; a_en_n = 1; a_wr_n = 1; a_oe_n = 1; a_busy_n = 1;
    b_addr = '0; b_en_n = 1; b_wr_n = 1; b_oe_n = 1; b_busy_n = 1;
  endtask

  // one clock: inputs set before, flags sampled at the following negedge
  task automatic tick();
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  task automatic a_acc(input logic [AW-1:0] ad, input logic wr, input logic oe);
    a_addr = ad; a_en_n = 0; a_wr_n = wr; a_oe_n = oe;
  endtask

  task automatic b_acc(input logic [AW-1:0] ad, input logic wr, input logic oe);
    b_addr = ad; b_en_n = 0; b_wr_n = wr; b_oe_n = oe;
  endtask

  task automatic t_reset();
    rst = 1; idle(); tick(); tick();
    chk("R1 a_irq_n after reset", a_irq_n, 1'b1);
    chk("R1 b_irq_n after reset", b_irq_n, 1'b1);
    rst = 0; tick();
  endtask

  task automatic t_set_clear_a();
    b_acc(MBA, 0, 1); tick();
    chk("R2 B write sets A flag", a_irq_n, 1'b0);
    chk("R2 B flag untouched", b_irq_n, 1'b1);
    a_acc(MBA, 1, 0); tick();
    chk("R4 A read clears A flag", a_irq_n, 1'b1);
    b_acc(MBA, 0, 1); tick();
    a_acc(MBA, 0, 0); tick();
    chk("R4 clear with wr_n low", a_irq_n, 1'b1);
  endtask

  task automatic t_set_clear_b();
    a_acc(MBB, 0, 1); tick();
    chk("R3 A write sets B flag", b_irq_n, 1'b0);
    chk("R3 A flag untouched", a_irq_n, 1'b1);
    b_acc(MBB, 1, 0); tick();
    chk("R5 B read clears B flag", b_irq_n, 1'b1);
    a_acc(MBB, 0, 1); tick();
    b_acc(MBB, 0, 0); tick();
    chk("R5 clear with wr_n low", b_irq_n, 1'b1);
  endtask

  task automatic t_busy();
    b_acc(MBA, 0, 1); b_busy_n = 0; tick();
    chk("R6 busy B blocks set of A", a_irq_n, 1'b1);
    a_acc(MBB, 0, 1); a_busy_n = 0; tick();
    chk("R6 busy A blocks set of B", b_irq_n, 1'b1);
    b_acc(MBA, 0, 1); tick();
    a_acc(MBA, 1, 0); a_busy_n = 0; tick();
    chk("R6 busy A blocks clear of A", a_irq_n, 1'b0);
    a_acc(MBA, 1, 0); tick();
    chk("R4 clear after busy drops", a_irq_n, 1'b1);
  endtask

  task automatic t_priority();
    a_acc(MBB, 0, 1); tick();
    a_acc(MBB, 0, 1); b_acc(MBB, 1, 0); tick();
    chk("R7 set beats clear on B", b_irq_n, 1'b0);
    b_acc(MBA, 0, 1); a_acc(MBA, 1, 0); tick();
    chk("R7 set beats clear on A", a_irq_n, 1'b0);
    a_acc(MBA, 1, 0); b_acc(MBB, 1, 0); tick();
    chk("R4 clear A", a_irq_n, 1'b1);
    chk("R5 clear B", b_irq_n, 1'b1);
  endtask

  task automatic t_ignored();
    a_acc(MBA, 0, 1); tick();
    chk("R8 A writing own box", a_irq_n, 1'b1);
    b_acc(MBA - 1, 0, 1); tick();
    chk("R8 other address", a_irq_n, 1'b1);
    b_addr = MBA; b_wr_n = 0; tick();
    chk("R8 en_n high write", a_irq_n, 1'b1);
    b_acc(MBA, 0, 1); tick();
    b_acc(MBA, 1, 0); tick();
    chk("R8 B read of A box keeps flag", a_irq_n, 1'b0);
    a_acc(MBA, 0, 1); tick();
    chk("R8 A write oe high keeps flag", a_irq_n, 1'b0);
    a_addr = MBA; a_oe_n = 0; tick();
    chk("R8 A read en_n high keeps flag", a_irq_n, 1'b0);
    a_acc(MBA, 1, 0); tick();
    chk("R4 final clear", a_irq_n, 1'b1);
  endtask

  initial begin
    rst = 1; idle();
    @(negedge clk);
    t_reset();
    t_set_clear_a();
    t_set_clear_b();
    t_busy();
    t_priority();
    t_ignored();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule